// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control of a 10-bit successive-approximation converter in a microcontroller. Software raises a start request. The sequencer opens the sample/hold switch at once. It then waits a short start delay if the slow free-running clock source is chosen. After that it tests the result bits one per conversion-clock period, from the most significant bit down to bit 0. For each test it drives a code to the DAC and reads back the comparator.

When the last period ends, the new code is written to the result register in the same clock edge that clears the busy bit and raises the completion flag. Until then the result register keeps its previous value. The sample switch closes again only at the first quarter-phase marker of the device clock after completion. The conversion clock is either the device clock divided by 2, 8 or 32, or a free-running enable input. The DAC, the comparator and the holding capacitor sit outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `goBusy`=0, `adif`=0, `result`=0, `dacCode`=0 and `sampleEn`=1.
- R2: A `goSet` pulse that is seen at a clock edge while the block is idle drives `sampleEn` to 0 after that same edge. `sampleEn` stays 0 for as long as `goBusy` is 1.
- R3: When `rcMode`=0 at start, the conversion clock is the device clock divided by D. The `divSel` codes are 0 for D=2, 1 for D=8, and 2 or 3 for D=32. `goBusy` falls exactly 11·D clock edges after the start edge.
- R4: When `rcMode`=1 at start, the block first waits 4 device clocks. It then counts 11 cycles in which `rcTick`=1, and `goBusy` falls at the edge that ends the 11th counted tick. A tick that falls inside the first 4 clocks after the start edge is not counted.
- R5: Each trial drives `dacCode` as the bits already decided, ORed with the bit under test. The bit is kept when `cmpHigh`=1, meaning the input is at or above the DAC level. As a result, `result` equals the held input code.
- R6: `result` keeps its previous value through the whole conversion.
- R7: At the edge where `goBusy` falls, `result` takes the new code and `adif` becomes 1.
- R8: `sampleEn` returns to 1 at the first clock edge after completion for which `q4Phase` was 1 in the preceding cycle, and not earlier.
- R9: A `goSet` pulse while a conversion is running has no effect on its length or its result.
- R10: `adif` stays 1 until an `adifClr` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q4Phase | input | 1 | High for one clock at the last quarter of each instruction cycle |
| rcMode | input | 1 | 1 selects the free-running enable as conversion clock |
| divSel | input | 2 | Divider code: 0 for /2, 1 for /8, 2 or 3 for /32 |
| rcTick | input | 1 | Free-running conversion clock enable for the slow clock mode |
| goSet | input | 1 | Software start request (one-clock pulse) |
| adifClr | input | 1 | Software clear of the completion flag |
| cmpHigh | input | 1 | Comparator: held input is at or above the DAC level |
| dacCode | output | 10 | Trial code to the DAC |
| sampleEn | output | 1 | 1 closes the sample switch |
| goBusy | output | 1 | Start/busy bit, reads 0 when done |
| result | output | 10 | Conversion result register |
| adif | output | 1 | Completion flag |

## Verification
The bench counts clock edges from the edge that takes `goSet`. In divided mode it expects `goBusy` to fall after exactly 11·D edges. In slow clock mode it replays its own `rcTick` pattern and finds the edge of the 11th tick that falls after the 4-clock delay. `result` and `adif` are checked at that same edge. The return of `sampleEn` is expected at the first later edge whose preceding cycle carried `q4Phase`, which the bench derives from its own cycle count. All values are sampled on the falling clock edge, half a cycle after the registers update.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_CONV   = 2'd2,
    ST_FINISH = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clearTrial;
    logic stepTrial;
    logic loadResult;
  } dpCmd_t;
endpackage

// File: rtl/sar_convclk.sv
module sar_convclk #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       useRc,
  input  logic [1:0] divCode,
  input  logic       rcTick,
  output logic       convTick
);
  localparam int CNT_W = $clog2(DIV_C + 1);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] termCnt;
  logic             divWrap;

  always_comb begin
    case (divCode)
      2'd0:    termCnt = CNT_W'(DIV_A - 1);
      2'd1:    termCnt = CNT_W'(DIV_B - 1);
      default: termCnt = CNT_W'(DIV_C - 1);
    endcase
  end

  assign divWrap = (divCnt == termCnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              divCnt <= '0;
    else if (!run || useRc)  divCnt <= '0;
    else if (divWrap)        divCnt <= '0;
    else                     divCnt <= divCnt + 1'b1;
  end

  assign convTick = run & (useRc ? rcTick : divWrap);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 10,
  parameter int START_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       goSet,
  input  logic       rcMode,
  input  logic [1:0] divSel,
  input  logic       q4Phase,
  input  logic       adifClr,
  input  logic       convTick,
  output logic       convRun,
  output logic       useRc,
  output logic [1:0] divCode,
  output dpCmd_t     cmd,
  output logic       goBusy,
  output logic       sampleEn,
  output logic       adif
);
  localparam int TICK_W = $clog2(WIDTH + 1);
  localparam int DLY_W  = $clog2(START_CLKS + 1);

  seqState_t        state, stateNext;
  logic [TICK_W-1:0] tickCnt;
  logic [DLY_W-1:0]  dlyCnt;
  logic              lastTick;
  logic              startNow;

  assign startNow = (state == ST_IDLE) && goSet;
  assign lastTick = (tickCnt == TICK_W'(WIDTH));

  always_comb begin
    stateNext      = state;
    cmd            = '0;
    case (state)
      ST_IDLE: begin
        if (goSet) begin
          cmd.clearTrial = 1'b1;
          stateNext      = rcMode ? ST_DELAY : ST_CONV;
        end
      end
      ST_DELAY: begin
        if (dlyCnt == DLY_W'(START_CLKS - 1)) stateNext = ST_CONV;
      end
      ST_CONV: begin
        if (convTick) begin
          if (lastTick) begin
            cmd.loadResult = 1'b1;
            stateNext      = ST_FINISH;
          end else begin
            cmd.stepTrial = 1'b1;
          end
        end
      end
      ST_FINISH: begin
        if (q4Phase) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      useRc   <= 1'b0;
      divCode <= 2'd0;
    end else if (startNow) begin
      useRc   <= rcMode;
      divCode <= divSel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dlyCnt <= '0;
    else if (state != ST_DELAY)  dlyCnt <= '0;
    else                         dlyCnt <= dlyCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tickCnt <= '0;
    else if (state != ST_CONV)           tickCnt <= '0;
    else if (convTick && !lastTick)      tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              adif <= 1'b0;
    else if (cmd.loadResult) adif <= 1'b1;
    else if (adifClr)        adif <= 1'b0;
  end

  assign convRun  = (state == ST_CONV);
  assign goBusy   = (state == ST_DELAY) || (state == ST_CONV);
  assign sampleEn = (state == ST_IDLE);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCmd_t           cmd,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] trialMask;
  logic [WIDTH-1:0] decided;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              trialMask <= '0;
    else if (cmd.clearTrial) trialMask <= {1'b1, {(WIDTH-1){1'b0}}};
    else if (cmd.stepTrial)  trialMask <= trialMask >> 1;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bitQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     bitQ <= 1'b0;
      else if (cmd.clearTrial)                        bitQ <= 1'b0;
      else if (cmd.stepTrial && trialMask[i] && cmpHigh) bitQ <= 1'b1;
    end
    assign decided[i] = bitQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              result <= '0;
    else if (cmd.loadResult) result <= decided;
  end

  assign dacCode = decided | trialMask;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 10,
  parameter int DIV_A      = 2,
  parameter int DIV_B      = 8,
  parameter int DIV_C      = 32,
  parameter int START_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q4Phase,
  input  logic             rcMode,
  input  logic [1:0]       divSel,
  input  logic             rcTick,
  input  logic             goSet,
  input  logic             adifClr,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic             sampleEn,
  output logic             goBusy,
  output logic [WIDTH-1:0] result,
  output logic             adif
);
  dpCmd_t     cmd;
  logic       convRun;
  logic       convTick;
  logic       useRc;
  logic [1:0] divCode;

  sar_ctrl #(.WIDTH(WIDTH), .START_CLKS(START_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .goSet(goSet), .rcMode(rcMode), .divSel(divSel),
    .q4Phase(q4Phase), .adifClr(adifClr), .convTick(convTick),
    .convRun(convRun), .useRc(useRc), .divCode(divCode), .cmd(cmd),
    .goBusy(goBusy), .sampleEn(sampleEn), .adif(adif)
  );

  sar_convclk #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(convRun), .useRc(useRc),
    .divCode(divCode), .rcTick(rcTick), .convTick(convTick)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .result(result)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q4Phase,
  input logic             goSet,
  input logic             adifClr,
  input logic             sampleEn,
  input logic             goBusy,
  input logic [WIDTH-1:0] result,
  input logic             adif
);
  AST_SWITCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    goBusy |-> !sampleEn); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (goBusy && $past(goBusy)) |-> $stable(result)); // R6

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(goBusy) |-> adif); // R7

  AST_RECONNECT_Q4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sampleEn) |-> $past(q4Phase)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adif) && !$past(adifClr)) |-> adif); // R10

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (goBusy && goSet) |=> (goBusy || adif)); // R9
endmodule

bind sar_seq_top sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .q4Phase(q4Phase), .goSet(goSet), .adifClr(adifClr),
  .sampleEn(sampleEn), .goBusy(goBusy), .result(result), .adif(adif)
);

// File: tb/tb_sar_seq_top.sv
`timescale 1ns/1ps
module tb_sar_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       q4Phase = 1'b0;
  logic       rcMode = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic       rcTick = 1'b0;
  logic       goSet = 1'b0;
  logic       adifClr = 1'b0;
  logic       cmpHigh;
  logic [9:0] dacCode;
  logic       sampleEn;
  logic       goBusy;
  logic [9:0] result;
  logic       adif;

  logic [9:0] vinLive = 10'd0;
  logic [9:0] heldVin = 10'd0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  sar_seq_top dut (
    .clk(clk), .rst_n(rst_n), .q4Phase(q4Phase), .rcMode(rcMode), .divSel(divSel),
    .rcTick(rcTick), .goSet(goSet), .adifClr(adifClr), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .sampleEn(sampleEn), .goBusy(goBusy), .result(result), .adif(adif)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    q4Phase <= ((cyc % 4) == 0);
    rcTick  <= ((cyc % 5) == 2);
  end

  // holding capacitor and comparator model
  always @(posedge clk) if (sampleEn === 1'b1) heldVin <= vinLive;
  assign cmpHigh = (heldVin >= dacCode);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int divOf(input logic [1:0] code);
    case (code)
      2'd0: return 2;
      2'd1: return 8;
      default: return 32;
    endcase
  endfunction

  task automatic runConv(input logic [9:0] v, input bit rc, input logic [1:0] ds, input bit poke);
    int c0, expN, cnt, k, elapsed, cd, j, expJ;
    logic [9:0] oldRes;
    bit heldOk;
    @(negedge clk);
    vinLive = v; rcMode = rc; divSel = ds;
    oldRes = result; goSet = 1'b1; c0 = cyc;
    @(negedge clk);
    goSet = 1'b0;
    check(sampleEn == 1'b0 && goBusy == 1'b1, "R2", sampleEn, 0);
    vinLive = ~v;
    if (!rc) expN = 11 * divOf(ds);
    else begin
      cnt = 0; expN = 0;
      for (int kk = 5; kk < 1000 && expN == 0; kk++) begin
        if (((c0 + kk) % 5) == 2) cnt++;
        if (cnt == 11) expN = kk;
      end
    end
    heldOk = 1; k = 0;
    while (goBusy && k < 2000) begin
      if (result != oldRes || sampleEn) heldOk = 0;
      if (poke && k == 3) goSet = 1'b1;
      else goSet = 1'b0;
      @(negedge clk);
      k++;
    end
    goSet = 1'b0;
    elapsed = cyc - c0 - 1;
    check(heldOk, "R6", result, oldRes);
    if (rc) check(elapsed == expN, "R4", elapsed, expN);
    else    check(elapsed == expN, poke ? "R9" : "R3", elapsed, expN);
    check(result == v, poke ? "R9" : "R5", result, v);
    check(adif == 1'b1, "R7", adif, 1);
    cd = cyc;
    expJ = 1;
    while (((cd + expJ - 1) % 4) != 0) expJ++;
    j = 0;
    while (!sampleEn && j < 20) begin
      @(negedge clk);
      j++;
    end
    check(j == expJ, "R8", j, expJ);
    repeat (3) @(negedge clk);
    check(adif == 1'b1, "R10", adif, 1);
    adifClr = 1'b1;
    @(negedge clk);
    adifClr = 1'b0;
    check(adif == 1'b0, "R10", adif, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(goBusy == 0 && adif == 0 && result == 0 && dacCode == 0 && sampleEn == 1,
          "R1", {goBusy, adif, sampleEn}, 1);
    // directed corners
    runConv(10'd0,    1'b0, 2'd0, 1'b0);
    runConv(10'd1023, 1'b0, 2'd1, 1'b0);
    runConv(10'd512,  1'b0, 2'd2, 1'b0);
    runConv(10'd511,  1'b0, 2'd3, 1'b0);
    runConv(10'd341,  1'b1, 2'd0, 1'b0);
    runConv(10'd682,  1'b0, 2'd1, 1'b1);
    runConv(10'd77,   1'b1, 2'd2, 1'b1);
    // constrained random
    for (int n = 0; n < 24; n++) begin
      runConv(10'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule